// File: doc/BRIEF.md
# Bus Slave Control Register File

This block is a memory-mapped slave on a 32-bit local bus clocked at 50 MHz. It gives software one flat window of word registers. The window holds an interrupt mask and an interrupt status, two scratch words, two independent 8-bit GPIO banks and a bank of four LEDs. It also carries the control words for a separate block-transfer engine, a read-only view of that engine's state, a revision word and sixteen words of general user memory. The bus side is a single write strobe with a byte address and write data. Read data is combinational from the address and is valid in the same cycle.

The two interrupt sources come from the transfer engine and from the flash programmer. Each source is gated by its mask bit, and the gated sources are merged into one request line. Each GPIO bank drives its pads through separate output-value and output-enable signals, so an external tri-state buffer can be placed at the pad ring. Each bank's pad inputs pass through a two-flop synchronizer before software can read them. The transfer engine and the flash programmer are outside this block, which only presents their control and status signals.

Top module: `ctl_regfile_top`

## Requirements
- R1: After reset every readable word returns zero, except the revision word at 0x3C, which returns the parameter REV_VALUE. After reset all GPIO output enables are 0, the LEDs are off, the transfer start, direction, address and count outputs are zero, and the interrupt request is low.
- R2: Word 0x00 is the interrupt mask. It is readable and writable in bits 1:0, and its upper bits read zero. Word 0x04 reads back the live sources: bit 0 is the transfer-engine source and bit 1 is the flash-programmer source. Writes to 0x04 have no effect.
- R3: The interrupt request is high exactly while at least one source bit is set together with its mask bit.
- R4: Words 0x08 and 0x0C are scratch words, and word 0x3C is the revision word. All three are readable and writable across all 32 bits.
- R5: The P bank has its output value at 0x10 and its direction at 0x14. The N bank has its output value at 0x1C and its direction at 0x20. Bits 7:0 of these words are used. A direction bit of 1 makes that pin an output: its output enable is 1 and its pad drives the output bit. A pin whose direction bit is 0 has its pad output held at 0.
- R6: Word 0x18 reads the P-bank pads and word 0x24 reads the N-bank pads, zero-extended to 32 bits. A pad change becomes visible in these words after two rising clock edges.
- R7: Bits 3:0 of word 0x2C drive LEDs 1 to 4.
- R8: In word 0x30, bit 0 drives the transfer start output and bit 1 drives the transfer direction output (1 for write, 0 for read). Words 0x34 and 0x38 drive the 32-bit destination-address output and the 32-bit DWORD-count output. Word 0x28 reads the transfer-state input.
- R9: Byte offsets 0x40 to 0x7C are sixteen readable and writable 32-bit user memory words.
- R10: A read of a write-only word (0x10, 0x14, 0x1C, 0x20, 0x2C, 0x30, 0x34, 0x38) returns zero. A read at any offset of 0x80 or above returns zero, and a write there changes nothing.
- R11: Address bits 1:0 are ignored, so every byte address selects the word that contains it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe; the write takes effect at the rising edge |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| src_xfer | input | 1 | Transfer-engine interrupt source |
| src_flash | input | 1 | Flash-programmer interrupt source |
| irq_o | output | 1 | Merged interrupt request |
| gp_p_i | input | GPIO_W | P-bank pad inputs |
| gp_p_o | output | GPIO_W | P-bank pad output values |
| gp_p_oe | output | GPIO_W | P-bank pad output enables |
| gp_n_i | input | GPIO_W | N-bank pad inputs |
| gp_n_o | output | GPIO_W | N-bank pad output values |
| gp_n_oe | output | GPIO_W | N-bank pad output enables |
| led_o | output | 4 | LED drives |
| xfer_state_i | input | 32 | Transfer-engine state for readback |
| xfer_start_o | output | 1 | Transfer start |
| xfer_write_o | output | 1 | Transfer direction, 1 for write |
| xfer_addr_o | output | 32 | Transfer destination address |
| xfer_count_o | output | 32 | Transfer length in DWORDs |

## Verification
Most of the state is held in registers whose values drive output ports directly. A corrupted LED, direction, output or transfer register therefore shows on its port at the next falling edge after the faulty write, and the bench compares every one of these ports after every operation. A wrong address decode shows up in one of two ways: a register with an unexpected value on its port, or a stale or aliased word in the memory or scratch readback. This appears on the first later read of that word, and the random mix of reads and writes, including writes above 0x7C, reaches those reads within a few operations. A synchronizer fault shows as GPIO readback data that arrives one cycle early or late around a pad change.

// File: rtl/ctl_regfile_pkg.sv
`timescale 1ns/1ps
package ctl_regfile_pkg;
   localparam int REG_WORDS = 16;
   localparam int BUS_DW    = 32;
   localparam int LED_W     = 4;
   localparam int N_IRQ     = 2;

   typedef enum logic [3:0] {
      W_IMASK  = 4'd0,
      W_ISRC   = 4'd1,
      W_SCR0   = 4'd2,
      W_SCR1   = 4'd3,
      W_POUT   = 4'd4,
      W_PDIR   = 4'd5,
      W_PIN    = 4'd6,
      W_NOUT   = 4'd7,
      W_NDIR   = 4'd8,
      W_NIN    = 4'd9,
      W_XSTATE = 4'd10,
      W_LED    = 4'd11,
      W_XCTRL  = 4'd12,
      W_XADDR  = 4'd13,
      W_XCNT   = 4'd14,
      W_REV    = 4'd15
   } reg_word_e;
endpackage

// File: rtl/ctl_gpio_bank.sv
`timescale 1ns/1ps
module ctl_gpio_bank #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_out,
   input  logic         wr_dir,
   input  logic [W-1:0] wdata,
   input  logic [W-1:0] pad_i,
   output logic [W-1:0] pad_o,
   output logic [W-1:0] pad_oe,
   output logic [W-1:0] pad_sync
);
   logic [W-1:0] out_q, dir_q, meta_q, sync_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_q  <= '0;
         dir_q  <= '0;
         meta_q <= '0;
         sync_q <= '0;
      end else begin
         if (wr_out) out_q <= wdata;
         if (wr_dir) dir_q <= wdata;
         meta_q <= pad_i;
         sync_q <= meta_q;
      end
   end

   assign pad_o    = out_q & dir_q;
   assign pad_oe   = dir_q;
   assign pad_sync = sync_q;
endmodule

// File: rtl/ctl_irq_unit.sv
`timescale 1ns/1ps
module ctl_irq_unit #(
   parameter int N_SRC = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_mask,
   input  logic [N_SRC-1:0] wdata,
   input  logic [N_SRC-1:0] src_i,
   output logic [N_SRC-1:0] mask_q,
   output logic             irq_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mask_q <= '0;
      else if (wr_mask) mask_q <= wdata;
   end

   assign irq_o = |(src_i & mask_q);
endmodule

// File: rtl/ctl_user_mem.sv
`timescale 1ns/1ps
module ctl_user_mem #(
   parameter int WORDS = 16,
   parameter int DW    = 32,
   localparam int IW   = $clog2(WORDS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr,
   input  logic [IW-1:0] idx,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata
);
   logic [DW-1:0] mem_q [WORDS];

   for (genvar i = 0; i < WORDS; i++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                        mem_q[i] <= '0;
         else if (wr && idx == IW'(i))      mem_q[i] <= wdata;
      end
   end

   assign rdata = mem_q[idx];
endmodule

// File: rtl/ctl_regfile_top.sv
`timescale 1ns/1ps
module ctl_regfile_top
   import ctl_regfile_pkg::*;
#(
   parameter int          ADDR_W    = 8,
   parameter int          GPIO_W    = 8,
   parameter int          MEM_WORDS = 16,
   parameter logic [31:0] REV_VALUE = 32'h0001_0200
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic              src_xfer,
   input  logic              src_flash,
   output logic              irq_o,
   input  logic [GPIO_W-1:0] gp_p_i,
   output logic [GPIO_W-1:0] gp_p_o,
   output logic [GPIO_W-1:0] gp_p_oe,
   input  logic [GPIO_W-1:0] gp_n_i,
   output logic [GPIO_W-1:0] gp_n_o,
   output logic [GPIO_W-1:0] gp_n_oe,
   output logic [3:0]        led_o,
   input  logic [31:0]       xfer_state_i,
   output logic              xfer_start_o,
   output logic              xfer_write_o,
   output logic [31:0]       xfer_addr_o,
   output logic [31:0]       xfer_count_o
);
   localparam int WIDX_W  = $clog2(REG_WORDS);
   localparam int MIDX_W  = $clog2(MEM_WORDS);
   localparam int REGION_LSB = WIDX_W + 2;
   localparam int N_BANK  = 2;

   if (ADDR_W < REGION_LSB + 1) begin : g_chk_aw
      $error("ADDR_W too small for register and memory windows");
   end
   if (MEM_WORDS != REG_WORDS) begin : g_chk_mem
      $error("user memory window must span exactly one register window");
   end
   if (GPIO_W < 1 || GPIO_W > BUS_DW) begin : g_chk_gpio
      $error("GPIO_W must lie in 1..32");
   end

   // address split: region selects registers (0) or memory (1)
   logic [ADDR_W-REGION_LSB-1:0] region;
   reg_word_e                    word;
   logic                         reg_hit, mem_hit, reg_wr;

   assign region  = bus_addr[ADDR_W-1:REGION_LSB];
   assign word    = reg_word_e'(bus_addr[REGION_LSB-1:2]);
   assign reg_hit = (region == '0);
   assign mem_hit = (region == (ADDR_W-REGION_LSB)'(1));
   assign reg_wr  = bus_wr & reg_hit;

   // interrupt
   logic [N_IRQ-1:0] src_vec, mask_q;
   assign src_vec = {src_flash, src_xfer};

   ctl_irq_unit #(.N_SRC(N_IRQ)) irq_i (
      .clk(clk), .rst_n(rst_n),
      .wr_mask(reg_wr && word == W_IMASK),
      .wdata(bus_wdata[N_IRQ-1:0]),
      .src_i(src_vec), .mask_q(mask_q), .irq_o(irq_o)
   );

   // GPIO banks: index 0 is P, index 1 is N
   logic [GPIO_W-1:0] bk_pad_i [N_BANK];
   logic [GPIO_W-1:0] bk_pad_o [N_BANK];
   logic [GPIO_W-1:0] bk_oe    [N_BANK];
   logic [GPIO_W-1:0] bk_sync  [N_BANK];
   reg_word_e         bk_out_w [N_BANK];
   reg_word_e         bk_dir_w [N_BANK];

   assign bk_pad_i[0] = gp_p_i;
   assign bk_pad_i[1] = gp_n_i;
   assign bk_out_w[0] = W_POUT;
   assign bk_dir_w[0] = W_PDIR;
   assign bk_out_w[1] = W_NOUT;
   assign bk_dir_w[1] = W_NDIR;

   for (genvar b = 0; b < N_BANK; b++) begin : g_bank
      ctl_gpio_bank #(.W(GPIO_W)) bank_i (
         .clk(clk), .rst_n(rst_n),
         .wr_out(reg_wr && word == bk_out_w[b]),
         .wr_dir(reg_wr && word == bk_dir_w[b]),
         .wdata(bus_wdata[GPIO_W-1:0]),
         .pad_i(bk_pad_i[b]),
         .pad_o(bk_pad_o[b]),
         .pad_oe(bk_oe[b]),
         .pad_sync(bk_sync[b])
      );
   end

   assign gp_p_o  = bk_pad_o[0];
   assign gp_p_oe = bk_oe[0];
   assign gp_n_o  = bk_pad_o[1];
   assign gp_n_oe = bk_oe[1];

   // user memory
   logic [31:0] mem_rdata;
   ctl_user_mem #(.WORDS(MEM_WORDS), .DW(BUS_DW)) mem_i (
      .clk(clk), .rst_n(rst_n),
      .wr(bus_wr & mem_hit),
      .idx(bus_addr[MIDX_W+1:2]),
      .wdata(bus_wdata),
      .rdata(mem_rdata)
   );

   // plain registers
   logic [31:0]      scr0_q, scr1_q, xaddr_q, xcnt_q, rev_q;
   logic [LED_W-1:0] led_q;
   logic [1:0]       xctrl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scr0_q  <= '0;
         scr1_q  <= '0;
         xaddr_q <= '0;
         xcnt_q  <= '0;
         rev_q   <= REV_VALUE;
         led_q   <= '0;
         xctrl_q <= '0;
      end else if (reg_wr) begin
         case (word)
            W_SCR0:  scr0_q  <= bus_wdata;
            W_SCR1:  scr1_q  <= bus_wdata;
            W_XADDR: xaddr_q <= bus_wdata;
            W_XCNT:  xcnt_q  <= bus_wdata;
            W_REV:   rev_q   <= bus_wdata;
            W_LED:   led_q   <= bus_wdata[LED_W-1:0];
            W_XCTRL: xctrl_q <= bus_wdata[1:0];
            default: ;
         endcase
      end
   end

   assign led_o        = led_q;
   assign xfer_start_o = xctrl_q[0];
   assign xfer_write_o = xctrl_q[1];
   assign xfer_addr_o  = xaddr_q;
   assign xfer_count_o = xcnt_q;

   // read mux; write-only words fall to zero
   logic [31:0] reg_rdata;
   always_comb begin
      reg_rdata = '0;
      case (word)
         W_IMASK:  reg_rdata[N_IRQ-1:0]  = mask_q;
         W_ISRC:   reg_rdata[N_IRQ-1:0]  = src_vec;
         W_SCR0:   reg_rdata             = scr0_q;
         W_SCR1:   reg_rdata             = scr1_q;
         W_PIN:    reg_rdata[GPIO_W-1:0] = bk_sync[0];
         W_NIN:    reg_rdata[GPIO_W-1:0] = bk_sync[1];
         W_XSTATE: reg_rdata             = xfer_state_i;
         W_REV:    reg_rdata             = rev_q;
         default:  reg_rdata             = '0;
      endcase
   end

   assign bus_rdata = reg_hit ? reg_rdata : (mem_hit ? mem_rdata : '0);
endmodule

// File: rtl/ctl_regfile_chk.sv
`timescale 1ns/1ps
module ctl_regfile_chk #(
   parameter int ADDR_W = 8,
   parameter int GPIO_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [31:0]       bus_wdata,
   input logic [31:0]       bus_rdata,
   input logic              src_xfer,
   input logic              src_flash,
   input logic              irq_o,
   input logic [GPIO_W-1:0] gp_p_i,
   input logic [GPIO_W-1:0] gp_p_o,
   input logic [GPIO_W-1:0] gp_p_oe,
   input logic [GPIO_W-1:0] gp_n_o,
   input logic [GPIO_W-1:0] gp_n_oe,
   input logic [3:0]        led_o
);
   logic [1:0] age_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            age_q <= '0;
      else if (age_q != 2'd2) age_q <= age_q + 2'd1;
   end

   logic [ADDR_W-1:0] wd;
   assign wd = bus_addr >> 2;

   AST_IRQ_AFTER_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && wd == 0) |=> (irq_o == |($past(bus_wdata[1:0]) & {src_flash, src_xfer}))); // R3

   AST_PAD_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      ((gp_p_o & ~gp_p_oe) == '0) && ((gp_n_o & ~gp_n_oe) == '0)); // R5

   AST_LED_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && wd == 11) |=> (led_o == $past(bus_wdata[3:0]))); // R7

   AST_WO_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (wd == 4 || wd == 5 || wd == 7 || wd == 8 || (wd >= 11 && wd <= 14) || wd >= 32)
      |-> (bus_rdata == '0)); // R10

   AST_SYNC_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
      (age_q == 2'd2 && wd == 6) |-> (bus_rdata[GPIO_W-1:0] == $past(gp_p_i, 2))); // R6

   AST_MEM_WRITE_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && wd >= 16 && wd < 32) |=>
      (bus_addr[ADDR_W-1:2] != $past(bus_addr[ADDR_W-1:2]) || bus_rdata == $past(bus_wdata))); // R9
endmodule

bind ctl_regfile_top ctl_regfile_chk #(.ADDR_W(ADDR_W), .GPIO_W(GPIO_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
   .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_xfer(src_xfer),
   .src_flash(src_flash), .irq_o(irq_o), .gp_p_i(gp_p_i), .gp_p_o(gp_p_o),
   .gp_p_oe(gp_p_oe), .gp_n_o(gp_n_o), .gp_n_oe(gp_n_oe), .led_o(led_o)
);

// File: tb/ctl_regfile_top_tb_top.sv
`timescale 1ns/1ps
module ctl_regfile_top_tb_top;
   localparam logic [31:0] REV = 32'h0001_0200;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        src_xfer = 1'b0, src_flash = 1'b0, irq_o;
   logic [7:0]  gp_p_i = '0, gp_n_i = '0, gp_p_o, gp_p_oe, gp_n_o, gp_n_oe;
   logic [3:0]  led_o;
   logic [31:0] xfer_state_i = '0, xfer_addr_o, xfer_count_o;
   logic        xfer_start_o, xfer_write_o;

   always #10 clk = ~clk;

   ctl_regfile_top #(.ADDR_W(8), .GPIO_W(8), .MEM_WORDS(16), .REV_VALUE(REV)) dut_i (.*);

   int checks = 0, errors = 0;
   bit done = 0;

   // bench model
   logic [1:0]  m_mask;
   logic [31:0] m_scr0, m_scr1, m_xaddr, m_xcnt, m_rev;
   logic [7:0]  m_pout, m_pdir, m_nout, m_ndir;
   logic [3:0]  m_led;
   logic [1:0]  m_ctrl;
   logic [31:0] m_mem [16];

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic model_reset();
      m_mask = '0; m_scr0 = '0; m_scr1 = '0; m_xaddr = '0; m_xcnt = '0; m_rev = REV;
      m_pout = '0; m_pdir = '0; m_nout = '0; m_ndir = '0; m_led = '0; m_ctrl = '0;
      for (int i = 0; i < 16; i++) m_mem[i] = '0;
   endtask

   task automatic model_write(logic [7:0] a, logic [31:0] d);
      if (a[7]) return;
      if (a[6]) begin m_mem[a[5:2]] = d; return; end
      case (a[5:2])
         4'd0:  m_mask  = d[1:0];
         4'd2:  m_scr0  = d;
         4'd3:  m_scr1  = d;
         4'd4:  m_pout  = d[7:0];
         4'd5:  m_pdir  = d[7:0];
         4'd7:  m_nout  = d[7:0];
         4'd8:  m_ndir  = d[7:0];
         4'd11: m_led   = d[3:0];
         4'd12: m_ctrl  = d[1:0];
         4'd13: m_xaddr = d;
         4'd14: m_xcnt  = d;
         4'd15: m_rev   = d;
         default: ;
      endcase
   endtask

   function automatic logic [31:0] exp_rd(logic [7:0] a);
      if (a[7]) return '0;
      if (a[6]) return m_mem[a[5:2]];
      case (a[5:2])
         4'd0:  return {30'b0, m_mask};
         4'd1:  return {30'b0, src_flash, src_xfer};
         4'd2:  return m_scr0;
         4'd3:  return m_scr1;
         4'd6:  return {24'b0, gp_p_i};
         4'd9:  return {24'b0, gp_n_i};
         4'd10: return xfer_state_i;
         4'd15: return m_rev;
         default: return '0;
      endcase
   endfunction

   task automatic bus_write(logic [7:0] a, logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
      model_write(a, d);
   endtask

   task automatic bus_read(string req, logic [7:0] a);
      bus_addr = a;
      #1;
      chk(req, bus_rdata, exp_rd(a));
   endtask

   task automatic check_ports();
      chk("R3 irq", {31'b0, irq_o}, {31'b0, |(m_mask & {src_flash, src_xfer})});
      chk("R5 p_oe", {24'b0, gp_p_oe}, {24'b0, m_pdir});
      chk("R5 p_o", {24'b0, gp_p_o}, {24'b0, m_pout & m_pdir});
      chk("R5 n_oe", {24'b0, gp_n_oe}, {24'b0, m_ndir});
      chk("R5 n_o", {24'b0, gp_n_o}, {24'b0, m_nout & m_ndir});
      chk("R7 led", {28'b0, led_o}, {28'b0, m_led});
      chk("R8 ctrl", {30'b0, xfer_write_o, xfer_start_o}, {30'b0, m_ctrl});
      chk("R8 addr", xfer_addr_o, m_xaddr);
      chk("R8 count", xfer_count_o, m_xcnt);
   endtask

   initial begin
      #(200000 * 20);
      if (!done) begin
         errors++;
         $display("FAIL watchdog act=%0d exp=%0d", checks, 0);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd7731));
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state, all words
      for (int w = 0; w < 64; w++) bus_read("R1 reset read", 8'(w * 4));
      check_ports();

      // R2 mask and source readback, source write ignored
      src_xfer = 1'b1; src_flash = 1'b0;
      bus_write(8'h04, 32'hFFFF_FFFF);
      bus_read("R2 src readonly", 8'h04);
      bus_write(8'h00, 32'hFFFF_FFFE);
      bus_read("R2 mask bits", 8'h00);
      chk("R3 masked off", {31'b0, irq_o}, 32'd0);
      src_flash = 1'b1; #1;
      chk("R3 flash on", {31'b0, irq_o}, 32'd1);
      bus_read("R2 src both", 8'h04);
      src_flash = 1'b0; #1;
      chk("R3 flash released", {31'b0, irq_o}, 32'd0);

      // R11 byte lanes ignored
      bus_write(8'h0B, 32'hA5A5_1234);
      bus_read("R11 scratch alias", 8'h08);
      bus_read("R11 scratch alias b", 8'h09);

      // R5 direction gating
      bus_write(8'h10, 32'h0000_00FF);
      check_ports();
      bus_write(8'h14, 32'h0000_000F);
      check_ports();
      bus_write(8'h20, 32'h0000_00F0);
      bus_write(8'h1C, 32'h0000_003C);
      check_ports();

      // R6 synchronizer latency
      @(negedge clk);
      gp_p_i = 8'h5A;
      @(negedge clk);
      bus_addr = 8'h18; #1;
      chk("R6 one edge old", bus_rdata, 32'h0);
      @(negedge clk); #1;
      chk("R6 two edges new", bus_rdata, 32'h5A);
      gp_n_i = 8'hC3;
      repeat (2) @(negedge clk);
      bus_read("R6 n bank", 8'h24);

      // R10 writes above window do not alias
      bus_write(8'h40, 32'h1111_2222);
      bus_write(8'hC0, 32'hDEAD_BEEF);
      bus_read("R10 mem unaliased", 8'h40);
      bus_read("R10 high reads zero", 8'hC0);

      // R8 state readback
      xfer_state_i = 32'h0000_0107;
      bus_read("R8 state", 8'h28);

      // constrained random mix
      for (int i = 0; i < 1500; i++) begin
         logic [7:0]  a;
         logic [31:0] d;
         int          r;
         r = int'($urandom % 8);
         a = (r == 0) ? 8'(8'h80 | $urandom) : 8'($urandom % 128);
         d = $urandom;
         if ($urandom % 16 == 0) begin
            @(negedge clk);
            gp_p_i = 8'($urandom); gp_n_i = 8'($urandom);
            repeat (2) @(negedge clk);
         end
         if ($urandom % 8 == 0) begin
            src_xfer = 1'($urandom); src_flash = 1'($urandom);
            xfer_state_i = $urandom;
         end
         if ($urandom % 2 == 0) bus_write(a, d);
         else begin
            @(negedge clk);
            bus_read("R4 R9 R10 random read", a);
         end
         check_ports();
      end

      // final sweep R4 R9
      for (int w = 0; w < 32; w++) bus_read("R4 R9 final sweep", 8'(w * 4));

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule